// File: doc/BRIEF.md
# Linked-Table Address Translator

This block sits between a trace-buffer writer and the memory system. It turns the writer's linear buffer address into a physical address. The buffer is described by a chain of 4 KB tables held in memory. Each table points to 256 data pages of 4 KB, so one table covers 1 MB of input space. The tables are joined to their neighbours by a previous link and a next link. For every request the unit finds the table that covers the address by stepping along these links one at a time, starting from the table it used last. It then reads the data-page pointer, appends the page offset and returns the result. If any entry it reads is marked invalid, it returns an error instead.

Software sets up the unit while it is disabled, through single-cycle write strobes:
- the address of the first table in the chain;
- the input base, which the unit aligns to 1 MB;
- the mode, pass-through or translate, which is latched at the moment of enabling.

In pass-through mode, addresses go straight through with no memory reads. Only one translation is in flight at a time. A status output shows when the unit is idle.

Top module: `tbl_xlate`

## Requirements
- R1: After reset the unit is disabled, `ready_o` is 1, and `in_ready_o`, `out_valid_o` and `mem_req_o` are 0.
- R2: A control write with `ctrl_en_i`=1, made while the unit is disabled and idle, does three things. It enables the unit, latches `ctrl_xlate_i` as the mode (1 = translate), and sets the current table to the table-base register with table number 0. The same write made while the unit is already enabled changes nothing: the current table is kept.
- R3: In pass-through mode an accepted address comes back unchanged, with `out_err_o`=0, on `out_valid_o` in the cycle after acceptance. No memory read is issued.
- R4: In translate mode, an input address a is split using the offset d = a − (input base aligned to 1 MB). The target table number is d[AW-1:20], the slot is d[19:12] and the page offset is d[11:0]. When the target is the current table, the unit makes exactly one read, at (current table address) + 8·slot. Entry bits [AW-1:12] hold the page address and bit 0 is the valid flag. The output is {entry[AW-1:12], d[11:0]}.
- R5: When the target table number is above the current one, the unit reads the next link at byte offset 0xFF8 (slot 511) of the current table. The valid link becomes the current table and the table number goes up by 1. This repeats one link per read until the target is reached.
- R6: When the target table number is below the current one, the unit reads the previous link at byte offset 0xFF0 (slot 510) in the same way, and the table number goes down by 1 per link.
- R7: A data-page entry with bit 0 clear ends the lookup with `out_err_o`=1 and `out_addr_o`=0.
- R8: A link entry with bit 0 clear ends the lookup with `out_err_o`=1 and `out_addr_o`=0. The current table stays at the last valid table reached.
- R9: `in_ready_o` is 0 from acceptance until the response handshake completes. While `out_valid_o`=1 and `out_ready_i`=0, the address and error outputs hold steady.
- R10: Writes to the table-base or input-base registers while the unit is enabled are ignored. Bits [19:0] of the input base are ignored.
- R11: After a disable write, `in_ready_o` stays 0. A walk already in flight still completes and delivers its response. `ready_o` returns to 1 once that response is taken.
- R12: Entry bits [11:1] have no effect on the output address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Enable value for a control write |
| ctrl_xlate_i | input | 1 | Mode for a control write (1 = translate) |
| tbase_we_i | input | 1 | Table-base write strobe |
| tbase_i | input | AW | Byte address of the first table |
| ibase_we_i | input | 1 | Input-base write strobe |
| ibase_i | input | AW | Input base address (aligned to 1 MB internally) |
| enabled_o | output | 1 | Unit enabled |
| ready_o | output | 1 | Unit idle |
| in_valid_i | input | 1 | Input address valid |
| in_ready_o | output | 1 | Input address accepted |
| in_addr_i | input | AW | Linear input address |
| out_valid_o | output | 1 | Response valid |
| out_ready_i | input | 1 | Response taken |
| out_addr_o | output | AW | Translated address |
| out_err_o | output | 1 | Lookup failed |
| mem_req_o | output | 1 | Entry read request, held until answered |
| mem_addr_o | output | AW | Entry byte address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 64 | Entry read data |

## Verification
The bench uses a chain of three tables and walks it in both directions. It checks the exact sequence of entry addresses read, so a unit that followed the wrong slot, or reset its position on every request, would show extra or misplaced reads. A null link past the last table, and an invalid data slot, must each end in an error rather than a hang. After a link error, the next translation must take a single read; a design that moved its position on a bad link would fail here. A redundant enable write, base writes made while enabled, and a disable issued in the middle of a walk each target the register-protection rules. A wrong design would restart from the first table, take the new bases, or drop the in-flight response.

// File: rtl/tbl_xlate_pkg.sv
package tbl_xlate_pkg;
  localparam int PAGE_SH = 12;
  localparam int TBL_SH  = 20;
  localparam int IDX_W   = TBL_SH - PAGE_SH;
  localparam int SLOT_W  = PAGE_SH - 3;
  localparam logic [SLOT_W-1:0] SLOT_PREV = SLOT_W'(510);
  localparam logic [SLOT_W-1:0] SLOT_NEXT = SLOT_W'(511);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} walk_st_e;
endpackage

// File: rtl/tbl_xlate_ent.sv
module tbl_xlate_ent
  import tbl_xlate_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic [63:0]         ent_i,
  output logic [AW-PAGE_SH-1:0] pg_o,
  output logic                v_o
);
  // bits 11..1 are reserved and dropped here
  assign pg_o = ent_i[AW-1:PAGE_SH];
  assign v_o  = ent_i[0];
endmodule

// File: rtl/tbl_xlate_cfg.sv
module tbl_xlate_cfg
  import tbl_xlate_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_we_i,
  input  logic                  ctrl_en_i,
  input  logic                  ctrl_xlate_i,
  input  logic                  tbase_we_i,
  input  logic [AW-1:0]         tbase_i,
  input  logic                  ibase_we_i,
  input  logic [AW-1:0]         ibase_i,
  input  logic                  idle_i,
  output logic                  en_o,
  output logic                  xlate_o,
  output logic                  load_o,
  output logic [AW-PAGE_SH-1:0] tbase_pg_o,
  output logic [AW-TBL_SH-1:0]  ibase_hi_o
);
  logic en_q, xlate_q;
  logic [AW-PAGE_SH-1:0] tbase_q;
  logic [AW-TBL_SH-1:0]  ibase_q;

  // enabling only from a fully drained, disabled state
  assign load_o = ctrl_we_i && ctrl_en_i && !en_q && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      xlate_q <= 1'b0;
      tbase_q <= '0;
      ibase_q <= '0;
    end else begin
      if (load_o) begin
        en_q    <= 1'b1;
        xlate_q <= ctrl_xlate_i;
      end else if (ctrl_we_i && !ctrl_en_i) begin
        en_q <= 1'b0;
      end
      if (tbase_we_i && !en_q) tbase_q <= tbase_i[AW-1:PAGE_SH];
      if (ibase_we_i && !en_q) ibase_q <= ibase_i[AW-1:TBL_SH];
    end
  end

  assign en_o       = en_q;
  assign xlate_o    = xlate_q;
  assign tbase_pg_o = tbase_q;
  assign ibase_hi_o = ibase_q;
endmodule

// File: rtl/tbl_xlate_walk.sv
module tbl_xlate_walk
  import tbl_xlate_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  xlate_i,
  input  logic                  load_i,
  input  logic [AW-PAGE_SH-1:0] load_pg_i,
  input  logic [AW-TBL_SH-1:0]  ibase_hi_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [AW-1:0]         in_addr_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [AW-1:0]         out_addr_o,
  output logic                  out_err_o,
  output logic                  mem_req_o,
  output logic [AW-1:0]         mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [AW-PAGE_SH-1:0] ent_pg_i,
  input  logic                  ent_v_i,
  output logic                  idle_o
);
  localparam int PW = AW - PAGE_SH;
  localparam int TW = AW - TBL_SH;

  walk_st_e           st_q;
  logic [PW-1:0]      cur_pg_q;
  logic [TW-1:0]      cur_num_q, tgt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PAGE_SH-1:0] off_q;
  logic [AW-1:0]      oaddr_q;
  logic               oerr_q;
  logic               go_fwd, go_back;
  logic [SLOT_W-1:0]  slot;

  assign go_fwd  = tgt_q > cur_num_q;
  assign go_back = tgt_q < cur_num_q;
  assign slot    = go_fwd ? SLOT_NEXT : go_back ? SLOT_PREV : {1'b0, idx_q};

  assign in_ready_o  = en_i && (st_q == ST_IDLE);
  assign out_valid_o = (st_q == ST_RESP);
  assign mem_req_o   = (st_q == ST_FETCH);
  assign idle_o      = (st_q == ST_IDLE);
  assign mem_addr_o  = {cur_pg_q, slot, 3'b000};
  assign out_addr_o  = oaddr_q;
  assign out_err_o   = oerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cur_pg_q  <= '0;
      cur_num_q <= '0;
      tgt_q     <= '0;
      idx_q     <= '0;
      off_q     <= '0;
      oaddr_q   <= '0;
      oerr_q    <= 1'b0;
    end else begin
      if (load_i) begin
        cur_pg_q  <= load_pg_i;
        cur_num_q <= '0;
      end
      unique case (st_q)
        ST_IDLE: if (in_valid_i && in_ready_o) begin
          tgt_q <= in_addr_i[AW-1:TBL_SH] - ibase_hi_i;
          idx_q <= in_addr_i[TBL_SH-1:PAGE_SH];
          off_q <= in_addr_i[PAGE_SH-1:0];
          if (xlate_i) begin
            st_q <= ST_FETCH;
          end else begin
            oaddr_q <= in_addr_i;
            oerr_q  <= 1'b0;
            st_q    <= ST_RESP;
          end
        end
        ST_FETCH: if (mem_rvalid_i) begin
          if (go_fwd || go_back) begin
            if (ent_v_i) begin
              cur_pg_q  <= ent_pg_i;
              cur_num_q <= go_fwd ? cur_num_q + TW'(1) : cur_num_q - TW'(1);
            end else begin
              oaddr_q <= '0;
              oerr_q  <= 1'b1;
              st_q    <= ST_RESP;
            end
          end else begin
            oaddr_q <= ent_v_i ? {ent_pg_i, off_q} : '0;
            oerr_q  <= !ent_v_i;
            st_q    <= ST_RESP;
          end
        end
        ST_RESP: if (out_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tbl_xlate.sv
module tbl_xlate
  import tbl_xlate_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          ctrl_en_i,
  input  logic          ctrl_xlate_i,
  input  logic          tbase_we_i,
  input  logic [AW-1:0] tbase_i,
  input  logic          ibase_we_i,
  input  logic [AW-1:0] ibase_i,
  output logic          enabled_o,
  output logic          ready_o,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [AW-1:0] in_addr_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [AW-1:0] out_addr_o,
  output logic          out_err_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [63:0]   mem_rdata_i
);
  logic                  en_w, xlate_w, load_w, idle_w, ent_v_w;
  logic [AW-PAGE_SH-1:0] tbase_pg_w, ent_pg_w;
  logic [AW-TBL_SH-1:0]  ibase_hi_w;

  tbl_xlate_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_en_i, .ctrl_xlate_i,
    .tbase_we_i, .tbase_i, .ibase_we_i, .ibase_i,
    .idle_i(idle_w), .en_o(en_w), .xlate_o(xlate_w), .load_o(load_w),
    .tbase_pg_o(tbase_pg_w), .ibase_hi_o(ibase_hi_w)
  );

  tbl_xlate_ent #(.AW(AW)) u_ent (
    .ent_i(mem_rdata_i), .pg_o(ent_pg_w), .v_o(ent_v_w)
  );

  tbl_xlate_walk #(.AW(AW)) u_walk (
    .clk_i, .rst_ni, .en_i(en_w), .xlate_i(xlate_w), .load_i(load_w),
    .load_pg_i(tbase_pg_w), .ibase_hi_i(ibase_hi_w),
    .in_valid_i, .in_ready_o, .in_addr_i,
    .out_valid_o, .out_ready_i, .out_addr_o, .out_err_o,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i,
    .ent_pg_i(ent_pg_w), .ent_v_i(ent_v_w), .idle_o(idle_w)
  );

  assign enabled_o = en_w;
  assign ready_o   = idle_w;
endmodule

// File: rtl/tbl_xlate_chk.sv
module tbl_xlate_chk #(
  parameter int AW = 40
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enabled_o,
  input logic          ready_o,
  input logic          xlate_w,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic [AW-1:0] in_addr_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [AW-1:0] out_addr_o,
  input logic          out_err_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i
);
  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !xlate_w) |=>
      (out_valid_o && !out_err_o && out_addr_o == $past(in_addr_i)));

  p_pass_nomem_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enabled_o && !xlate_w) |-> !mem_req_o);

  p_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_addr_o) && $stable(out_err_o)));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!mem_req_o && !out_valid_o));

  p_off_closed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled_o |-> !in_ready_o);
endmodule

bind tbl_xlate tbl_xlate_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enabled_o(enabled_o), .ready_o(ready_o),
  .xlate_w(xlate_w), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .in_addr_i(in_addr_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_addr_o(out_addr_o), .out_err_o(out_err_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/tbl_xlate_tb.sv
`timescale 1ns/1ps
module tbl_xlate_tb;
  localparam int AW = 40;
  localparam logic [AW-1:0] T0 = 40'h00_0010_0000;
  localparam logic [AW-1:0] T1 = 40'h00_0020_0000;
  localparam logic [AW-1:0] T2 = 40'h00_0030_5000;
  localparam logic [AW-1:0] IB = 40'h40_1000_0000;
  localparam logic [AW-1:0] DA = 40'hA0_0000_5000;
  localparam logic [AW-1:0] DB = 40'hB1_2345_6000;
  localparam logic [AW-1:0] DC = 40'hC0_0000_0000;
  localparam logic [AW-1:0] DD = 40'hC0_00FF_F000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, ctrl_en = 0, ctrl_xlate = 0;
  logic tbase_we = 0, ibase_we = 0;
  logic [AW-1:0] tbase = '0, ibase = '0, in_addr = '0;
  logic in_valid = 0, out_ready = 1;
  logic enabled, ready, in_ready, out_valid, out_err, mem_req;
  logic [AW-1:0] out_addr, mem_addr;
  logic mem_rvalid = 0;
  logic [63:0] mem_rdata = '0;

  int total = 0, bad = 0, wait_cnt = 0;
  logic [63:0] mem [logic [AW-1:0]];
  logic [AW-1:0] rlog [$];

  always #4 clk = ~clk;

  tbl_xlate #(.AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en),
    .ctrl_xlate_i(ctrl_xlate), .tbase_we_i(tbase_we), .tbase_i(tbase),
    .ibase_we_i(ibase_we), .ibase_i(ibase), .enabled_o(enabled), .ready_o(ready),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_addr_i(in_addr),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .out_err_o(out_err), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // memory model: answers a held request after two cycles
  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
    end else if (mem_req) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        rlog.push_back(mem_addr);
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        mem_rvalid = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] lin(input int t, input int i, input int o);
    return IB + (AW'(t) << 20) + (AW'(i) << 12) + AW'(o);
  endfunction

  task automatic ctrl(input logic en, input logic x);
    ctrl_we = 1; ctrl_en = en; ctrl_xlate = x;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic xlate(input logic [AW-1:0] a, output logic [AW-1:0] oa, output logic oe);
    rlog.delete();
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_addr = a;
    @(negedge clk); in_valid = 0;
    while (!out_valid) @(negedge clk);
    oa = out_addr; oe = out_err;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 enabled", 64'(enabled), 0);
    chk("R1 ready", 64'(ready), 1);
    chk("R1 in_ready", 64'(in_ready), 0);
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 mem_req", 64'(mem_req), 0);
  endtask

  task automatic t_pass;
    ctrl(1, 0);
    rlog.delete();
    in_valid = 1; in_addr = 40'h12_3456_789A;
    @(negedge clk); in_valid = 0;
    chk("R3 next-cycle valid", 64'(out_valid), 1);
    chk("R3 addr", 64'(out_addr), 64'(40'h12_3456_789A));
    chk("R3 err", 64'(out_err), 0);
    @(negedge clk);
    chk("R3 no reads", 64'(rlog.size()), 0);
    ctrl(0, 0);
  endtask

  task automatic t_setup;
    tbase_we = 1; tbase = T0; ibase_we = 1; ibase = IB | 40'h0_0ABC; // R10 low bits dropped
    @(negedge clk); tbase_we = 0; ibase_we = 0;
    ctrl(1, 1);
    chk("R2 enabled", 64'(enabled), 1);
  endtask

  task automatic t_table0;
    logic [AW-1:0] oa; logic oe;
    xlate(lin(0, 5, 12'h123), oa, oe);
    chk("R4 addr", 64'(oa), 64'(DA | 40'h123));
    chk("R4 err", 64'(oe), 0);
    chk("R4 reads", 64'(rlog.size()), 1);
    chk("R4 slot addr", 64'(rlog[0]), 64'(T0 + 40'h28));
  endtask

  task automatic t_forward;
    logic [AW-1:0] oa; logic oe;
    xlate(lin(2, 0, 7), oa, oe);
    chk("R5 addr", 64'(oa), 64'(DC | 40'h7));
    chk("R5 reads", 64'(rlog.size()), 3);
    if (rlog.size() == 3) begin
      chk("R5 link0", 64'(rlog[0]), 64'(T0 + 40'hFF8));
      chk("R5 link1", 64'(rlog[1]), 64'(T1 + 40'hFF8));
      chk("R5 data", 64'(rlog[2]), 64'(T2));
    end
  endtask

  task automatic t_backward;
    logic [AW-1:0] oa; logic oe;
    xlate(lin(1, 3, 12'hABC), oa, oe);
    chk("R6 R12 addr", 64'(oa), 64'(DB | 40'hABC));
    chk("R6 reads", 64'(rlog.size()), 2);
    if (rlog.size() == 2) begin
      chk("R6 link", 64'(rlog[0]), 64'(T2 + 40'hFF0));
      chk("R6 data", 64'(rlog[1]), 64'(T1 + 40'h18));
    end
  endtask

  task automatic t_reenable;
    logic [AW-1:0] oa; logic oe;
    ctrl(1, 1);
    xlate(lin(1, 3, 0), oa, oe);
    chk("R2 kept table reads", 64'(rlog.size()), 1);
    chk("R2 addr", 64'(oa), 64'(DB));
  endtask

  task automatic t_base_lock;
    logic [AW-1:0] oa; logic oe;
    tbase_we = 1; tbase = 40'h00_0099_9000; ibase_we = 1; ibase = 40'h77_0000_0000;
    @(negedge clk); tbase_we = 0; ibase_we = 0;
    ctrl(0, 0);
    ctrl(1, 1);
    xlate(lin(0, 5, 12'h123), oa, oe);
    chk("R10 reads", 64'(rlog.size()), 1);
    if (rlog.size() == 1) chk("R10 R2 base", 64'(rlog[0]), 64'(T0 + 40'h28));
    chk("R10 addr", 64'(oa), 64'(DA | 40'h123));
  endtask

  task automatic t_bad_data;
    logic [AW-1:0] oa; logic oe;
    xlate(lin(0, 7, 1), oa, oe);
    chk("R7 err", 64'(oe), 1);
    chk("R7 addr", 64'(oa), 0);
  endtask

  task automatic t_bad_link;
    logic [AW-1:0] oa; logic oe;
    xlate(lin(3, 0, 0), oa, oe);
    chk("R8 err", 64'(oe), 1);
    chk("R8 reads", 64'(rlog.size()), 3);
    if (rlog.size() == 3) chk("R8 null link", 64'(rlog[2]), 64'(T2 + 40'hFF8));
    xlate(lin(2, 255, 12'h010), oa, oe);
    chk("R8 position kept", 64'(rlog.size()), 1);
    if (rlog.size() == 1) chk("R8 slot", 64'(rlog[0]), 64'(T2 + 40'h7F8));
    chk("R8 addr", 64'(oa), 64'(DD | 40'h010));
  endtask

  task automatic t_hold;
    logic [AW-1:0] a0;
    out_ready = 0;
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_addr = lin(2, 0, 7);
    @(negedge clk); in_valid = 0;
    chk("R9 busy", 64'(in_ready), 0);
    while (!out_valid) @(negedge clk);
    a0 = out_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", 64'(out_valid), 1);
      chk("R9 held addr", 64'(out_addr), 64'(a0));
      chk("R9 no accept", 64'(in_ready), 0);
    end
    chk("R9 value", 64'(a0), 64'(DC | 40'h7));
    out_ready = 1;
    @(negedge clk);
  endtask

  task automatic t_disable;
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_addr = lin(0, 5, 12'h123);
    @(negedge clk); in_valid = 0;
    ctrl(0, 0);
    chk("R11 disabled", 64'(enabled), 0);
    chk("R11 busy", 64'(ready), 0);
    while (!out_valid) @(negedge clk);
    chk("R11 drained addr", 64'(out_addr), 64'(DA | 40'h123));
    @(negedge clk);
    chk("R11 ready", 64'(ready), 1);
    chk("R11 closed", 64'(in_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[T0 + 40'h28]  = 64'(DA) | 64'h1;
    mem[T0 + 40'h38]  = 64'(40'hA0_0000_7000);
    mem[T0 + 40'hFF8] = 64'(T1) | 64'h1;
    mem[T1 + 40'h18]  = 64'(DB) | 64'h7FF;
    mem[T1 + 40'hFF0] = 64'(T0) | 64'h1;
    mem[T1 + 40'hFF8] = 64'(T2) | 64'h1;
    mem[T2]           = 64'(DC) | 64'h1;
    mem[T2 + 40'h7F8] = 64'(DD) | 64'h1;
    mem[T2 + 40'hFF0] = 64'(T1) | 64'h1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_setup();
    t_table0();
    t_forward();
    t_backward();
    t_reenable();
    t_base_lock();
    t_bad_data();
    t_bad_link();
    t_hold();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule